// File: doc/BRIEF.md
# Three-Channel Multi-Mode Timer Counter

This block holds three 8-bit timer channels that share one free-running prescaler. Each channel has a count register, a modulo register, an equality comparator, a toggle flip-flop that can drive an output pin, and a sticky interrupt request. A channel counts prescaled clock ticks. When its count equals its modulo value, the next tick clears the count, flips the output flip-flop and raises the request.

Channels 1 and 2 can also work together. Their two mode fields form a 4-bit code that selects one of four arrangements: three independent counters, a pulse-width output on channel 2, a single 16-bit counter built from channels 1 and 2, or a carrier generator. In the carrier generator, channel 1's output gates the fast square wave of channel 2. Software programs the block through a simple write port and can read any count through a select input at any time.

Top module: `tri_timer`

## Requirements
- R1: After reset all counts read 0, all three output pins are low and all three interrupt requests are clear.
- R2: The clock select field picks a tick every 2^(4+2·sel) clocks for channels 0 and 2, and every 2^(5+2·sel) clocks for channel 1.
- R3: In independent counting, a tick that finds count == modulo clears the count, flips the channel flip-flop and sets its request. Any other tick increments the count, so the pin toggles every (modulo+1) ticks and the count never exceeds the modulo value.
- R4: A pin stays low while its output enable bit (control bit 5) is 0, even though the channel keeps counting.
- R5: A request stays set until a 1 is pulsed on its bit of `irqAck`. The acknowledge clears it on the next clock edge.
- R6: `rdData` shows the count of the channel picked by `rdSel` (0, 1 or 2; the value 3 reads 0). Reading does not change any count.
- R7: The mode code is {ch1 ctrl[1:0], ch2 ctrl[1:0]}. 0000 selects independent counting, 0001 pulse-width, 1010 16-bit and 0011 carrier. Every other code behaves as 0000. Bits 1:0 of channel 0's control register always hold 0.
- R8: In pulse-width mode, the channel 2 pin is high while count2 < duty (address 7) and low otherwise. The period is modulo2+1 ticks, and request 2 is set once per period.
- R9: In 16-bit mode, channel 2's tick advances {count1,count2}, and count2 carries into count1. A match on {mod1,mod2} clears both counts, flips channel 1's flip-flop and sets request 1. Request 2 is never set in this mode.
- R10: In carrier mode, the channel 2 pin equals flip-flop 2 AND gate AND enable 2. The gate takes channel 1's flip-flop value at each channel 2 match.
- R11: Writing a channel's control register (address 0, 1 or 2) clears its count. A write to channel 1 or channel 2 clears both of those counts.
- R12: A channel whose run bit (control bit 4) is 0 holds its count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, also the prescaler source |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 3 | 0-2 control ch0-2, 4-6 modulo ch0-2, 7 duty; 3 unused |
| wrData | input | 8 | Write data; control layout {oe[5], run[4], sel[3:2], mode[1:0]} |
| irqAck | input | 3 | Per-channel request clear pulse |
| rdSel | input | 2 | Channel whose count appears on rdData |
| rdData | output | 8 | Selected count value |
| tout | output | 3 | Channel output pins |
| irqReq | output | 3 | Sticky match interrupt requests |

## Verification
The embedded assertions check these properties on every cycle: a count moves only on its tick or its restart strobe, a flip-flop changes only on a matching tick, a request rises only after a matching tick, request 2 stays quiet in the 16-bit arrangement, and channel 0's reserved mode bits remain zero. Several behaviours can only be shown by the bench scenarios, because they depend on periods measured at the pins. These are the exact tick spacing per clock select, toggle periods of (modulo+1) ticks, the pulse-width high time across a full window, the 16-bit period, and the way the carrier follows channel 1.

// File: rtl/tri_timer_pkg.sv
`timescale 1ns/1ps
package tri_timer_pkg;

  typedef enum logic [1:0] {
    MODE_IND     = 2'd0,
    MODE_PWM     = 2'd1,
    MODE_CAS16   = 2'd2,
    MODE_CARRIER = 2'd3
  } tmode_e;

  // strobes passed from control to datapath each cycle
  typedef struct packed {
    logic [2:0] tick;     // prescaled tick, already gated by run bit
    logic [2:0] restart;  // count clear after a control write
    logic [2:0] ack;      // request clear
    tmode_e     mode;     // decoded cross-channel arrangement
  } strobe_t;

endpackage

// File: rtl/tri_timer_ctrl.sv
`timescale 1ns/1ps
module tri_timer_ctrl
  import tri_timer_pkg::*;
#(
  parameter int DW    = 8,
  parameter int BASE0 = 4,
  parameter int BASE1 = 5,
  parameter int BASE2 = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic [2:0]         wrAddr,
  input  logic [DW-1:0]      wrData,
  input  logic [2:0]         irqAck,
  output strobe_t            stb,
  output logic [2:0]         oe,
  output logic [2:0][DW-1:0] modVal,
  output logic [DW-1:0]      duty
);

  localparam int MAXB  = (BASE0 > BASE1) ? ((BASE0 > BASE2) ? BASE0 : BASE2)
                                         : ((BASE1 > BASE2) ? BASE1 : BASE2);
  localparam int PRE_W = MAXB + 6;
  localparam int CW    = 6;

  logic [PRE_W-1:0]    pre;
  logic [2:0][CW-1:0]  ctrlReg;
  logic [2:0]          rawTick;
  logic [2:0]          wrCtl;
  logic [3:0]          modeCode;
  tmode_e              mode;

  always_ff @(posedge clk) begin
    if (!rstN) pre <= '0;
    else       pre <= pre + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlReg <= '0;
      modVal  <= '0;
      duty    <= '0;
    end else if (wrEn) begin
      case (wrAddr)
        3'd0: ctrlReg[0] <= {wrData[5:2], 2'b00};
        3'd1: ctrlReg[1] <= wrData[5:0];
        3'd2: ctrlReg[2] <= wrData[5:0];
        3'd4: modVal[0]  <= wrData;
        3'd5: modVal[1]  <= wrData;
        3'd6: modVal[2]  <= wrData;
        3'd7: duty       <= wrData;
        default: ;
      endcase
    end
  end

  for (genvar g = 0; g < 3; g++) begin : gTick
    localparam int B = (g == 0) ? BASE0 : ((g == 1) ? BASE1 : BASE2);
    logic [4:0]       expo;
    logic [PRE_W-1:0] mask;
    always_comb begin
      expo       = 5'(B) + {2'b00, ctrlReg[g][3:2], 1'b0};
      mask       = (PRE_W'(1) << expo) - PRE_W'(1);
      rawTick[g] = ((pre & mask) == mask);
    end
    assign oe[g]    = ctrlReg[g][5];
    assign wrCtl[g] = wrEn && (wrAddr == 3'(g));
  end

  assign modeCode = {ctrlReg[1][1:0], ctrlReg[2][1:0]};

  always_comb begin
    case (modeCode)
      4'b0001: mode = MODE_PWM;
      4'b1010: mode = MODE_CAS16;
      4'b0011: mode = MODE_CARRIER;
      default: mode = MODE_IND;
    endcase
  end

  always_comb begin
    stb.mode       = mode;
    stb.ack        = irqAck;
    stb.tick[0]    = rawTick[0] & ctrlReg[0][4];
    stb.tick[1]    = rawTick[1] & ctrlReg[1][4] & (mode != MODE_CAS16);
    stb.tick[2]    = rawTick[2] & ctrlReg[2][4];
    stb.restart[0] = wrCtl[0];
    stb.restart[1] = wrCtl[1] | wrCtl[2];
    stb.restart[2] = wrCtl[1] | wrCtl[2];
  end

  // R7: reserved channel 0 mode bits never hold a one
  assert_ch0_bits_zero_R7: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr == 3'd0) |=> (ctrlReg[0][1:0] == 2'b00));

endmodule

// File: rtl/tri_timer_dp.sv
`timescale 1ns/1ps
module tri_timer_dp
  import tri_timer_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  strobe_t            stb,
  input  logic [2:0]         oe,
  input  logic [2:0][DW-1:0] modVal,
  input  logic [DW-1:0]      duty,
  input  logic [1:0]         rdSel,
  output logic [DW-1:0]      rdData,
  output logic [2:0]         tout,
  output logic [2:0]         irqReq
);

  localparam int WW = 2 * DW;

  logic [2:0][DW-1:0] cnt, cntNxt;
  logic [2:0]         tff, tffNxt;
  logic [2:0]         irq, irqSet;
  logic [2:0]         match;
  logic               gate, gateNxt;
  logic               match16;
  logic [WW-1:0]      wide, wideNxt;
  logic               pwmOut;
  logic [2:0]         pinRaw;

  for (genvar g = 0; g < 3; g++) begin : gCmp
    assign match[g] = (cnt[g] == modVal[g]);
  end

  assign wide    = {cnt[1], cnt[2]};
  assign match16 = (wide == {modVal[1], modVal[2]});
  assign wideNxt = wide + 1'b1;

  always_comb begin
    cntNxt = cnt;
    tffNxt = tff;
    irqSet = '0;
    gateNxt = gate;
    for (int i = 0; i < 3; i++) begin
      if (stb.restart[i]) begin
        cntNxt[i] = '0;
      end else if (stb.tick[i]) begin
        if (match[i]) begin
          cntNxt[i] = '0;
          irqSet[i] = 1'b1;
          if (!(i == 2 && stb.mode == MODE_PWM)) tffNxt[i] = ~tff[i];
        end else begin
          cntNxt[i] = cnt[i] + 1'b1;
        end
      end
    end
    if (stb.mode == MODE_CAS16) begin
      irqSet[2:1] = 2'b00;
      tffNxt[2:1] = tff[2:1];
      if (stb.restart[2]) begin
        cntNxt[1] = '0;
        cntNxt[2] = '0;
      end else if (stb.tick[2]) begin
        if (match16) begin
          cntNxt[1] = '0;
          cntNxt[2] = '0;
          tffNxt[1] = ~tff[1];
          irqSet[1] = 1'b1;
        end else begin
          {cntNxt[1], cntNxt[2]} = wideNxt;
        end
      end
    end
    if (stb.mode == MODE_CARRIER && stb.tick[2] && match[2] && !stb.restart[2])
      gateNxt = tff[1];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt  <= '0;
      tff  <= '0;
      irq  <= '0;
      gate <= 1'b0;
    end else begin
      cnt  <= cntNxt;
      tff  <= tffNxt;
      irq  <= (irq & ~stb.ack) | irqSet;
      gate <= gateNxt;
    end
  end

  assign pwmOut = (cnt[2] < duty);

  always_comb begin
    pinRaw[0] = tff[0];
    pinRaw[1] = tff[1];
    case (stb.mode)
      MODE_PWM:     pinRaw[2] = pwmOut;
      MODE_CARRIER: pinRaw[2] = tff[2] & gate;
      default:      pinRaw[2] = tff[2];
    endcase
  end

  assign tout   = pinRaw & oe;
  assign irqReq = irq;

  always_comb begin
    case (rdSel)
      2'd0:    rdData = cnt[0];
      2'd1:    rdData = cnt[1];
      2'd2:    rdData = cnt[2];
      default: rdData = '0;
    endcase
  end

  // R12: counts stay put without a tick or restart
  assert_hold_ch0_R12: assert property (@(posedge clk) disable iff (!rstN)
    (!stb.tick[0] && !stb.restart[0]) |=> $stable(cnt[0]));
  assert_hold_ch2_R12: assert property (@(posedge clk) disable iff (!rstN)
    (!stb.tick[2] && !stb.restart[2]) |=> $stable(cnt[2]));
  // R3: flip-flop and request move only on a matching tick
  assert_tff_on_match_R3: assert property (@(posedge clk) disable iff (!rstN)
    !(stb.tick[0] && match[0]) |=> $stable(tff[0]));
  assert_irq_on_match_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irq[0]) |-> $past(stb.tick[0] && match[0]));
  // R9: low half never raises its request in 16-bit mode
  assert_no_low_irq_R9: assert property (@(posedge clk) disable iff (!rstN)
    (stb.mode == MODE_CAS16 && !irq[2]) |=> !irq[2]);

endmodule

// File: rtl/tri_timer.sv
`timescale 1ns/1ps
module tri_timer
  import tri_timer_pkg::*;
#(
  parameter int DW    = 8,
  parameter int BASE0 = 4,
  parameter int BASE1 = 5,
  parameter int BASE2 = 4
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          wrEn,
  input  logic [2:0]    wrAddr,
  input  logic [DW-1:0] wrData,
  input  logic [2:0]    irqAck,
  input  logic [1:0]    rdSel,
  output logic [DW-1:0] rdData,
  output logic [2:0]    tout,
  output logic [2:0]    irqReq
);

  strobe_t            stb;
  logic [2:0]         oe;
  logic [2:0][DW-1:0] modVal;
  logic [DW-1:0]      duty;

  tri_timer_ctrl #(.DW(DW), .BASE0(BASE0), .BASE1(BASE1), .BASE2(BASE2)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .irqAck(irqAck), .stb(stb), .oe(oe), .modVal(modVal), .duty(duty)
  );

  tri_timer_dp #(.DW(DW)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .oe(oe), .modVal(modVal), .duty(duty),
    .rdSel(rdSel), .rdData(rdData), .tout(tout), .irqReq(irqReq)
  );

endmodule

// File: tb/tri_timer_bench.sv
`timescale 1ns/1ps
module tri_timer_bench;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic [2:0] wrAddr = '0;
  logic [7:0] wrData = '0;
  logic [2:0] irqAck = '0;
  logic [1:0] rdSel = '0;
  logic [7:0] rdData;
  logic [2:0] tout;
  logic [2:0] irqReq;

  int nChk = 0;
  int nBad = 0;

  always #2.5 clk = ~clk;

  tri_timer u_tri_timer (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .irqAck(irqAck), .rdSel(rdSel), .rdData(rdData), .tout(tout), .irqReq(irqReq)
  );

  function automatic logic [7:0] mk(logic oe, logic run, logic [1:0] sel, logic [1:0] mb);
    return {2'b00, oe, run, sel, mb};
  endfunction

  task automatic chk(string req, int act, int exp);
    nChk++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic ackAll();
    @(negedge clk);
    irqAck = 3'b111;
    @(negedge clk);
    irqAck = 3'b000;
  endtask

  task automatic idleAll();
    wr(3'd0, 8'h00); wr(3'd1, 8'h00); wr(3'd2, 8'h00);
    ackAll();
  endtask

  task automatic waitCyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic measurePeriod(int ch, output int per);
    logic prev;
    int n;
    per = -1;
    prev = tout[ch]; n = 0;
    while (tout[ch] == prev && n < 20000) begin @(negedge clk); n++; end
    prev = tout[ch]; n = 0;
    while (tout[ch] == prev && n < 20000) begin @(negedge clk); n++; end
    if (n < 20000) per = n;
  endtask

  task automatic testReset();
    @(negedge clk);
    chk("R1 pins", int'(tout), 0);
    chk("R1 requests", int'(irqReq), 0);
    for (int s = 0; s < 3; s++) begin
      rdSel = 2'(s); #1;
      chk("R1 count", int'(rdData), 0);
    end
  endtask

  task automatic testClockSelect();
    int per;
    idleAll();
    wr(3'd4, 8'd0); wr(3'd5, 8'd0); wr(3'd6, 8'd0);
    for (int k = 0; k < 4; k++) begin
      wr(3'd0, mk(1, 1, 2'(k), 2'b00));
      measurePeriod(0, per);
      chk("R2 ch0 tick spacing", per, 16 << (2 * k));
    end
    wr(3'd0, 8'h00);
    for (int k = 0; k < 2; k++) begin
      wr(3'd1, mk(1, 1, 2'(k), 2'b00));
      measurePeriod(1, per);
      chk("R2 ch1 tick spacing", per, 32 << (2 * k));
    end
    wr(3'd1, 8'h00);
    wr(3'd2, mk(1, 1, 2'd1, 2'b00));
    measurePeriod(2, per);
    chk("R2 ch2 tick spacing", per, 64);
  endtask

  task automatic testMatch();
    int per, mx;
    idleAll();
    wr(3'd4, 8'd4);
    wr(3'd0, mk(1, 1, 2'd0, 2'b00));
    measurePeriod(0, per);
    chk("R3 toggle period", per, 80);
    chk("R3 request set", int'(irqReq[0]), 1);
    rdSel = 2'd0; mx = 0;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (int'(rdData) > mx) mx = int'(rdData);
    end
    chk("R3 count peak", mx, 4);
  endtask

  task automatic testEnable();
    int hi, per;
    idleAll();
    wr(3'd4, 8'd0);
    wr(3'd0, mk(0, 1, 2'd0, 2'b00));
    hi = 0;
    for (int i = 0; i < 200; i++) begin @(negedge clk); if (tout[0]) hi++; end
    chk("R4 disabled pin", hi, 0);
    chk("R4 channel still counts", int'(irqReq[0]), 1);
    wr(3'd0, mk(1, 1, 2'd0, 2'b00));
    measurePeriod(0, per);
    chk("R4 enabled pin toggles", per, 16);
  endtask

  task automatic testIrq();
    idleAll();
    wr(3'd4, 8'd0);
    wr(3'd0, mk(0, 1, 2'd0, 2'b00));
    waitCyc(40);
    wr(3'd0, 8'h00);
    waitCyc(100);
    chk("R5 request sticky", int'(irqReq[0]), 1);
    @(negedge clk); irqAck = 3'b010;
    @(negedge clk); irqAck = 3'b000;
    chk("R5 other ack ignored", int'(irqReq[0]), 1);
    @(negedge clk); irqAck = 3'b001;
    @(negedge clk); irqAck = 3'b000;
    chk("R5 ack clears", int'(irqReq[0]), 0);
  endtask

  task automatic testReadback();
    idleAll();
    wr(3'd6, 8'd200);
    wr(3'd2, mk(0, 1, 2'd0, 2'b00));
    rdSel = 2'd2;
    waitCyc(160);
    chk("R6 count after 10 ticks", int'(rdData), 10);
    rdSel = 2'd0; waitCyc(8);
    rdSel = 2'd1; waitCyc(8);
    rdSel = 2'd2; #1;
    chk("R6 count undisturbed by reads", int'(rdData), 11);
    wr(3'd2, mk(0, 1, 2'd0, 2'b00));
    chk("R11 control write clears", int'(rdData), 0);
    waitCyc(48);
    wr(3'd2, mk(0, 0, 2'd0, 2'b00));
    waitCyc(200);
    chk("R12 stopped channel holds", int'(rdData), 0);
  endtask

  task automatic testReservedCode();
    int per;
    idleAll();
    wr(3'd5, 8'd0); wr(3'd6, 8'd0);
    wr(3'd1, mk(1, 1, 2'd0, 2'b01));
    wr(3'd2, mk(1, 1, 2'd0, 2'b10));
    measurePeriod(2, per);
    chk("R7 reserved code ch2 independent", per, 16);
    measurePeriod(1, per);
    chk("R7 reserved code ch1 independent", per, 32);
  endtask

  task automatic pwmWindow(int d, int exp);
    int hi;
    wr(3'd7, 8'(d));
    waitCyc(200);
    hi = 0;
    for (int i = 0; i < 1600; i++) begin @(negedge clk); if (tout[2]) hi++; end
    chk("R8 high time", hi, exp);
  endtask

  task automatic testPwm();
    idleAll();
    wr(3'd6, 8'd9);
    wr(3'd7, 8'd3);
    wr(3'd2, mk(1, 1, 2'd0, 2'b01));
    pwmWindow(3, 480);
    chk("R8 period request", int'(irqReq[2]), 1);
    pwmWindow(0, 0);
    pwmWindow(12, 1600);
  endtask

  task automatic testWide();
    int per;
    idleAll();
    wr(3'd5, 8'd1); wr(3'd6, 8'd2);
    wr(3'd1, mk(1, 0, 2'd3, 2'b10));
    wr(3'd2, mk(0, 1, 2'd0, 2'b10));
    waitCyc(4096);
    rdSel = 2'd1; #1;
    chk("R9 carry into high byte", int'(rdData), 1);
    rdSel = 2'd2; #1;
    chk("R9 low byte wrapped", int'(rdData), 0);
    measurePeriod(1, per);
    chk("R9 16-bit period", per, 259 * 16);
    chk("R9 high request", int'(irqReq[1]), 1);
    chk("R9 low request quiet", int'(irqReq[2]), 0);
  endtask

  task automatic testCarrier();
    int rises, bad, lowRun;
    logic prev;
    idleAll();
    wr(3'd5, 8'd7); wr(3'd6, 8'd0);
    wr(3'd1, mk(1, 1, 2'd0, 2'b00));
    wr(3'd2, mk(1, 1, 2'd0, 2'b11));
    waitCyc(300);
    rises = 0; bad = 0; lowRun = 0; prev = tout[2];
    for (int i = 0; i < 2048; i++) begin
      @(negedge clk);
      if (tout[2] && !prev) rises++;
      prev = tout[2];
      lowRun = tout[1] ? 0 : lowRun + 1;
      if (lowRun >= 20 && tout[2]) bad++;
    end
    chk("R10 carrier off while gate low", bad, 0);
    chk("R10 carrier bursts present", int'(rises >= 24 && rises <= 40), 1);
  endtask

  initial begin
    repeat (180000) @(posedge clk);
    nBad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testClockSelect();
    testMatch();
    testEnable();
    testIrq();
    testReadback();
    testReservedCode();
    testPwm();
    testWide();
    testCarrier();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

endmodule